// File: doc/BRIEF.md
# Registered 8-bit ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator-style processor core. Each clock it takes an operation code, the accumulator, the X index register, an operand byte and the current status byte. One cycle later it presents a result byte, a code naming the register that should take the result, and the updated status byte. The instruction decoder feeds it, and the register file and memory stage use its outputs.

Sixteen operations are covered: add and subtract with carry, compare against the accumulator or X, AND, OR, XOR, bit test, increment, decrement, the two shifts, the two rotates through carry, a combined AND-then-subtract whose result is written to X, and a pass-through. Arithmetic is always binary. Status bit 0 is carry (C), bit 1 is zero (Z), bit 6 is overflow (V) and bit 7 is negative (N). Bits 2 to 5 are control bits that this block never changes.

Top module: `alu8_core`

## Requirements
- R1: Status bits 2, 3, 4 and 5 on `stat_o` equal the same bits of `stat_i` from the previous cycle, for every operation.
- R2: Op 0 (add) forms acc + opnd + C in 9 bits. The low byte is the result, bit 8 is the new C, and V is set when acc and opnd share a sign and the result sign differs from acc. Z and N follow the result.
- R3: Op 1 (subtract) forms acc − opnd − (1 − C). C is set when no borrow occurs, and V is set when acc and opnd differ in sign and the result sign differs from acc. Z and N follow the result.
- R4: Op 2 compares acc and op 3 compares X with opnd. The result byte is the low byte of the difference and the destination is none (0). Z and N follow the difference, C is set when the register is greater than or equal to opnd, and V is unchanged.
- R5: Ops 4, 5 and 6 form acc AND, OR and XOR opnd into the accumulator. Only Z and N change.
- R6: Op 7 (bit test) sets Z when (acc AND opnd) is zero and copies opnd bits 7 and 6 into N and V. The result byte is acc, the destination is none, and C is unchanged.
- R7: Ops 8 and 9 add or subtract one from opnd, modulo 256, into the operand destination. Only Z and N change.
- R8: Op 10 shifts opnd left and op 11 shifts it right, each filling the vacated bit with 0. The bit shifted out becomes C. After a right shift N is always clear.
- R9: Op 12 rotates opnd left and op 13 rotates it right. The old C fills the vacated bit and the bit shifted out becomes the new C.
- R10: Op 14 computes (acc AND X) − opnd. The low byte goes to X (destination 2), Z and N follow it, C is set when no borrow occurs, and V is unchanged.
- R11: The destination codes are: 0 for none (ops 2, 3, 7 and 15), 1 for the accumulator (ops 0, 1, 4, 5 and 6), 2 for X (op 14) and 3 for the operand (ops 8 to 13). Op 15 returns acc with the status unchanged.
- R12: Outputs change one clock after their inputs are sampled. A synchronous active-high `rst` clears all outputs to zero.
- R13: Status bit 3 (decimal) has no effect: add and subtract give binary results whatever its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| acc_i | input | 8 | Accumulator value |
| xreg_i | input | 8 | X index register value |
| opnd_i | input | 8 | Operand byte |
| stat_i | input | 8 | Current status byte |
| res_o | output | 8 | Registered result byte |
| dest_o | output | 2 | Registered destination code |
| stat_o | output | 8 | Registered updated status byte |

## Verification
The embedded assertions check these properties on every cycle after reset:
- the four control bits of the status byte pass through unchanged;
- N is clear after a right shift;
- bit test copies opnd bits into N and V;
- compare and bit test select no destination;
- increment wraps modulo 256.

Carry and overflow values, the borrow sense of subtract and of the AND-then-subtract, and the effect of the decimal bit can only be shown by the bench's scenarios. The bench runs a hand-checked vector table and a wide sweep of operands and carry values for every operation, compared against an independent model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int FC = 0;
  localparam int FZ = 1;
  localparam int FV = 6;
  localparam int FN = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMPA = 4'd2,
    OP_CMPX = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_BIT  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_SHL  = 4'd10,
    OP_SHR  = 4'd11,
    OP_ROL  = 4'd12,
    OP_ROR  = 4'd13,
    OP_ANDS = 4'd14,
    OP_PASS = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    DST_NONE = 2'd0,
    DST_ACC  = 2'd1,
    DST_X    = 2'd2,
    DST_OPND = 2'd3
  } alu_dst_e;

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'd0,
    UNIT_LOGIC = 2'd1,
    UNIT_SHIFT = 2'd2,
    UNIT_PASS  = 2'd3
  } alu_unit_e;

  function automatic alu_dst_e dest_of(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: dest_of = DST_ACC;
      OP_ANDS:                               dest_of = DST_X;
      OP_INC, OP_DEC, OP_SHL, OP_SHR,
      OP_ROL, OP_ROR:                        dest_of = DST_OPND;
      default:                               dest_of = DST_NONE;
    endcase
  endfunction

  function automatic alu_unit_e unit_of(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_CMPA, OP_CMPX, OP_ANDS: unit_of = UNIT_ARITH;
      OP_AND, OP_OR, OP_XOR, OP_BIT:             unit_of = UNIT_LOGIC;
      OP_PASS:                                   unit_of = UNIT_PASS;
      default:                                   unit_of = UNIT_SHIFT;
    endcase
  endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] x,
  input  logic [W-1:0] m,
  input  logic [7:0]   p,
  output logic [W-1:0] res,
  output logic [7:0]   p_out
);
  localparam int MSB = W - 1;

  logic [W-1:0] lhs;
  logic [W:0]   wide;
  logic         carry;
  logic         ovf;
  logic         borrow_in;

  always_comb begin
    case (op)
      OP_CMPX: lhs = x;
      OP_ANDS: lhs = a & x;
      default: lhs = a;
    endcase
    borrow_in = (op == OP_SUB) ? ~p[FC] : 1'b0;
    if (op == OP_ADD) begin
      wide  = {1'b0, a} + {1'b0, m} + {{W{1'b0}}, p[FC]};
      carry = wide[W];
      ovf   = (a[MSB] == m[MSB]) && (wide[MSB] != a[MSB]);
    end else begin
      wide  = {1'b0, lhs} - {1'b0, m} - {{W{1'b0}}, borrow_in};
      carry = ~wide[W];
      ovf   = (a[MSB] != m[MSB]) && (wide[MSB] != a[MSB]);
    end
    res       = wide[W-1:0];
    p_out     = p;
    p_out[FC] = carry;
    p_out[FZ] = (wide[W-1:0] == '0);
    p_out[FN] = wide[MSB];
    if (op == OP_ADD || op == OP_SUB) p_out[FV] = ovf;
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] m,
  input  logic [7:0]   p,
  output logic [W-1:0] res,
  output logic [7:0]   p_out
);
  localparam int MSB = W - 1;

  always_comb begin
    p_out = p;
    case (op)
      OP_AND:  res = a & m;
      OP_OR:   res = a | m;
      OP_XOR:  res = a ^ m;
      default: res = a;
    endcase
    if (op == OP_BIT) begin
      p_out[FZ] = ((a & m) == '0);
      p_out[FN] = m[MSB];
      p_out[FV] = m[MSB-1];
    end else begin
      p_out[FZ] = (res == '0);
      p_out[FN] = res[MSB];
    end
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] m,
  input  logic [7:0]   p,
  output logic [W-1:0] res,
  output logic [7:0]   p_out
);
  localparam int MSB = W - 1;

  logic fill_lo;
  logic fill_hi;

  always_comb begin
    fill_lo = (op == OP_ROL) ? p[FC] : 1'b0;
    fill_hi = (op == OP_ROR) ? p[FC] : 1'b0;
    p_out   = p;
    case (op)
      OP_INC: res = m + 1'b1;
      OP_DEC: res = m - 1'b1;
      OP_SHL, OP_ROL: begin
        res       = {m[MSB-1:0], fill_lo};
        p_out[FC] = m[MSB];
      end
      default: begin
        res       = {fill_hi, m[MSB:1]};
        p_out[FC] = m[0];
      end
    endcase
    p_out[FZ] = (res == '0);
    p_out[FN] = res[MSB];
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] xreg_i,
  input  logic [W-1:0] opnd_i,
  input  logic [7:0]   stat_i,
  output logic [W-1:0] res_o,
  output logic [1:0]   dest_o,
  output logic [7:0]   stat_o
);
  localparam int MSB = W - 1;

  alu_op_e      op;
  logic [W-1:0] ar_res, lg_res, sh_res;
  logic [7:0]   ar_p, lg_p, sh_p;
  logic [W-1:0] nxt_res;
  logic [7:0]   nxt_p;

  assign op = alu_op_e'(op_i);

  alu8_arith #(.W(W)) u_arith (
    .op(op), .a(acc_i), .x(xreg_i), .m(opnd_i), .p(stat_i),
    .res(ar_res), .p_out(ar_p)
  );

  alu8_logic #(.W(W)) u_logic (
    .op(op), .a(acc_i), .m(opnd_i), .p(stat_i),
    .res(lg_res), .p_out(lg_p)
  );

  alu8_shift #(.W(W)) u_shift (
    .op(op), .m(opnd_i), .p(stat_i),
    .res(sh_res), .p_out(sh_p)
  );

  always_comb begin
    case (unit_of(op))
      UNIT_ARITH: begin nxt_res = ar_res; nxt_p = ar_p; end
      UNIT_LOGIC: begin nxt_res = lg_res; nxt_p = lg_p; end
      UNIT_SHIFT: begin nxt_res = sh_res; nxt_p = sh_p; end
      default:    begin nxt_res = acc_i;  nxt_p = stat_i; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o  <= '0;
      dest_o <= 2'd0;
      stat_o <= 8'd0;
    end else begin
      res_o  <= nxt_res;
      dest_o <= dest_of(op);
      stat_o <= nxt_p;
    end
  end

  logic primed;
  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  AST_CTRL_BITS_KEPT: assert property (@(posedge clk) disable iff (rst)
    primed |-> stat_o[5:2] == $past(stat_i[5:2])); // R1

  AST_SHR_N_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_i) == OP_SHR) |-> !stat_o[FN]); // R8

  AST_BIT_COPIES_NV: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_i) == OP_BIT) |-> stat_o[FN:FV] == $past(opnd_i[MSB:MSB-1])); // R6

  AST_TEST_NO_DEST: assert property (@(posedge clk) disable iff (rst)
    (primed && ($past(op_i) == OP_CMPA || $past(op_i) == OP_CMPX || $past(op_i) == OP_BIT))
      |-> dest_o == DST_NONE); // R4

  AST_INC_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_i) == OP_INC && $past(opnd_i) == {W{1'b1}})
      |-> (res_o == '0 && stat_o[FZ])); // R7

  AST_ANDS_TO_X: assert property (@(posedge clk) disable iff (rst)
    (primed && $past(op_i) == OP_ANDS) |-> dest_o == DST_X); // R10
endmodule

// File: tb/alu8_core_tb_top.sv
`timescale 1ns/1ps
module alu8_core_tb_top;
  localparam real CLK_NS = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0;
  logic [7:0] acc_i = '0, xreg_i = '0, opnd_i = '0, stat_i = '0;
  logic [7:0] res_o, stat_o;
  logic [1:0] dest_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_NS/2) clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .xreg_i(xreg_i),
    .opnd_i(opnd_i), .stat_i(stat_i), .res_o(res_o), .dest_o(dest_o), .stat_o(stat_o)
  );

  // {op, acc, x, opnd, stat_in, res, dest, stat_out}
  localparam int NV = 18;
  localparam logic [53:0] VEC [NV] = '{
    {4'd0,  8'h50, 8'h00, 8'h50, 8'h00, 8'hA0, 2'd1, 8'hC0}, // R2 overflow
    {4'd0,  8'hFF, 8'h00, 8'h01, 8'h00, 8'h00, 2'd1, 8'h03}, // R2 carry
    {4'd1,  8'h50, 8'h00, 8'hB0, 8'h01, 8'hA0, 2'd1, 8'hC0}, // R3 overflow
    {4'd1,  8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 2'd1, 8'h80}, // R3 borrow in
    {4'd2,  8'h40, 8'h00, 8'h40, 8'h00, 8'h00, 2'd0, 8'h03}, // R4 equal
    {4'd3,  8'h00, 8'h10, 8'h20, 8'hC1, 8'hF0, 2'd0, 8'hC0}, // R4 X less
    {4'd7,  8'h0F, 8'h00, 8'hC0, 8'h00, 8'h0F, 2'd0, 8'hC2}, // R6
    {4'd11, 8'h00, 8'h00, 8'h81, 8'h80, 8'h40, 2'd3, 8'h01}, // R8 right
    {4'd10, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 2'd3, 8'h03}, // R8 left
    {4'd13, 8'h00, 8'h00, 8'h01, 8'h01, 8'h80, 2'd3, 8'h81}, // R9 right
    {4'd12, 8'h00, 8'h00, 8'h80, 8'h00, 8'h00, 2'd3, 8'h03}, // R9 left
    {4'd8,  8'h00, 8'h00, 8'hFF, 8'h41, 8'h00, 2'd3, 8'h43}, // R7 wrap up
    {4'd9,  8'h00, 8'h00, 8'h00, 8'h02, 8'hFF, 2'd3, 8'h80}, // R7 wrap down
    {4'd14, 8'hF0, 8'h3C, 8'h10, 8'h00, 8'h20, 2'd2, 8'h01}, // R10
    {4'd14, 8'h0F, 8'h0F, 8'h20, 8'h01, 8'hEF, 2'd2, 8'h80}, // R10 borrow
    {4'd6,  8'hFF, 8'h00, 8'hFF, 8'h80, 8'h00, 2'd1, 8'h02}, // R5
    {4'd0,  8'h09, 8'h00, 8'h01, 8'h08, 8'h0A, 2'd1, 8'h08}, // R13
    {4'd15, 8'h5A, 8'h00, 8'h00, 8'hFD, 8'h5A, 2'd0, 8'hFD}  // R11 pass
  };

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R2";  4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      4'd10, 4'd11: return "R8";
      4'd12, 4'd13: return "R9";
      4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [17:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] x,
                                        logic [7:0] m, logic [7:0] p);
    logic [8:0] t;
    logic [7:0] r, po, nm;
    logic [1:0] d;
    logic       zn;
    nm = ~m; po = p; r = a; d = 2'd0; zn = 1'b1; t = '0;
    case (op)
      4'd0: begin t = {1'b0,a} + {1'b0,m} + {8'd0,p[0]}; r = t[7:0]; po[0] = t[8];
                  po[6] = ~(a[7]^m[7]) & (a[7]^r[7]); d = 2'd1; end
      4'd1: begin t = {1'b0,a} + {1'b0,nm} + {8'd0,p[0]}; r = t[7:0]; po[0] = t[8];
                  po[6] = (a[7]^m[7]) & (a[7]^r[7]); d = 2'd1; end
      4'd2: begin t = {1'b0,a} + {1'b0,nm} + 9'd1; r = t[7:0]; po[0] = t[8]; end
      4'd3: begin t = {1'b0,x} + {1'b0,nm} + 9'd1; r = t[7:0]; po[0] = t[8]; end
      4'd4: begin r = a & m; d = 2'd1; end
      4'd5: begin r = a | m; d = 2'd1; end
      4'd6: begin r = a ^ m; d = 2'd1; end
      4'd7: begin zn = 1'b0; po[1] = ((a & m) == 8'd0); po[7] = m[7]; po[6] = m[6]; end
      4'd8: begin r = m + 8'd1; d = 2'd3; end
      4'd9: begin r = m - 8'd1; d = 2'd3; end
      4'd10: begin r = {m[6:0], 1'b0}; po[0] = m[7]; d = 2'd3; end
      4'd11: begin r = {1'b0, m[7:1]}; po[0] = m[0]; d = 2'd3; end
      4'd12: begin r = {m[6:0], p[0]}; po[0] = m[7]; d = 2'd3; end
      4'd13: begin r = {p[0], m[7:1]}; po[0] = m[0]; d = 2'd3; end
      4'd14: begin t = {1'b0,a & x} + {1'b0,nm} + 9'd1; r = t[7:0]; po[0] = t[8]; d = 2'd2; end
      default: zn = 1'b0;
    endcase
    if (zn) begin po[1] = (r == 8'd0); po[7] = r[7]; end
    return {r, d, po};
  endfunction

  logic        have_prev = 1'b0;
  logic [17:0] prev_exp;
  logic [3:0]  prev_op;

  task automatic check(string req, logic [17:0] got, logic [17:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%h dest=%0d stat=%h, expected res=%h dest=%0d stat=%h",
               req, got[17:10], got[9:8], got[7:0], exp[17:10], exp[9:8], exp[7:0]);
    end
  endtask

  // pipelined: each negedge checks the vector driven one cycle earlier, then drives the next
  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] x, logic [7:0] m,
                       logic [7:0] p, logic [17:0] exp);
    @(negedge clk);
    if (have_prev) check(req_of(prev_op), {res_o, dest_o, stat_o}, prev_exp);
    op_i = op; acc_i = a; xreg_i = x; opnd_i = m; stat_i = p;
    prev_exp = exp; prev_op = op; have_prev = 1'b1;
  endtask

  task automatic flush();
    @(negedge clk);
    if (have_prev) check(req_of(prev_op), {res_o, dest_o, stat_o}, prev_exp);
    have_prev = 1'b0;
  endtask

  logic done = 1'b0;

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R12: reset state with busy inputs
    op_i = 4'd0; acc_i = 8'hFF; opnd_i = 8'hFF; stat_i = 8'hFF;
    repeat (3) @(negedge clk);
    check("R12", {res_o, dest_o, stat_o}, 18'd0);
    rst = 1'b0;

    // hand-checked table
    for (int i = 0; i < NV; i++)
      apply(VEC[i][53:50], VEC[i][49:42], VEC[i][41:34], VEC[i][33:26], VEC[i][25:18], VEC[i][17:0]);
    flush();

    // R1 R13: control bits untouched across every op, decimal bit set
    for (int op = 0; op < 16; op++)
      apply(4'(op), 8'h3C, 8'hA5, 8'h81, 8'h3D, model(4'(op), 8'h3C, 8'hA5, 8'h81, 8'h3D));
    flush();

    // sweep of every op over operand, carry and flag patterns
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 16; ai++)
        for (int m = 0; m < 256; m++)
          for (int c = 0; c < 2; c++) begin
            logic [7:0] a, x, p;
            a = 8'(ai * 17);
            x = a ^ 8'h5A ^ 8'(m);
            p = {8'(m) ^ a} & 8'hFE | 8'(c);
            apply(4'(op), a, x, 8'(m), p, model(4'(op), a, x, 8'(m), p));
          end
    flush();

    // R12: reset mid-stream clears outputs after one edge
    @(negedge clk);
    op_i = 4'd0; acc_i = 8'h7F; opnd_i = 8'h01; stat_i = 8'hFF; rst = 1'b1;
    @(negedge clk);
    check("R12", {res_o, dest_o, stat_o}, 18'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R12", {res_o, dest_o, stat_o}, model(4'd0, 8'h7F, 8'h00, 8'h01, 8'hFF));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule